// File: doc/BRIEF.md
# Load/Store Instruction Decoder

This block is a purely combinational decoder for 32-bit load/store instruction words. It sorts the word into one of six recognised encoding families (register offset, unsigned 12-bit immediate, ordered acquire/release, weakly ordered acquire load, exclusive load, exclusive store). For that family it produces a flat micro-operation: a direction bit, the access size, the register indices, the offset operand and the memory-ordering flags. Any word outside these families gives a deasserted valid flag, and every other output is then zero.

The design is built as a two-stage chain. A classifier plays the part of the state register. It settles on one named family (`FORM_NONE`, `FORM_REG`, `FORM_IMM`, `FORM_ORD`, `FORM_RCPC`, `FORM_LDX`, `FORM_STX`) through a `unique case` on the opcode group bits. A builder plays the part of the output process. It turns the chosen family plus the raw word into the micro-operation. There are no clocked transitions. The only "transition" is the combinational move from the raw word to one family, and from that family to the output fields.

Bit positions below are numbered 31 (MSB) to 0. In every family, bits [31:30] are the size, [9:5] the base index and [4:0] the data index.

Top module: `ldst_decode`

## Requirements
- R1: For every valid word, `size_o` equals bits [31:30]. This is the log2 of the access byte count (0..3 → 1, 2, 4 or 8 bytes).
- R2: Register-offset family: bits [29:24]=111000, [21]=1, [11:10]=10. It is valid only when option [15:13]=011, the shift bit [12]=0 and opc [23:22] is 00 or 01. On a valid word, `off_is_reg_o`=1, `rm_o` = bits [20:16] used as is, `off_imm_o`=0 and all ordering flags are 0.
- R3: In the register-offset and immediate families, opc 01 gives a load (`is_load_o`=1) and opc 00 gives a store. Opc 10 or 11 gives an invalid word (apart from the weakly ordered family of R6).
- R4: Immediate family: bits [29:24]=111001. `off_imm_o` is bits [21:10] zero-extended to the offset width. `off_is_reg_o`=0, `rm_o`=0 and all ordering flags are 0.
- R5: Ordered family: [29:23]=0010001, [21]=0, [20:16]=11111, [15]=1, [14:10]=11111. Bit [22]=1 gives a load with `acq_o`=1. Bit [22]=0 gives a store with `rel_o`=1. The offset is zero and `excl_o`=0.
- R6: Weakly ordered load family: [29:21]=111000101, [20:16]=11111, [15:10]=110000. It gives a load with `acq_o`=1, `rcpc_o`=1, a zero offset and `excl_o`=0.
- R7: Exclusive load family: [29:21]=001000010, [20:16]=11111, [14:10]=11111. It gives a load with `excl_o`=1 and a zero offset, and `acq_o` = bit [15].
- R8: Exclusive store family: [29:21]=001000000, [14:10]=11111. It gives a store with `excl_o`=1, a zero offset, `rel_o` = bit [15], `status_vld_o`=1 and `status_idx_o` = bits [20:16].
- R9: Outside the exclusive store family, `status_vld_o`=0 and `status_idx_o`=0.
- R10: The flags agree with each other. `rcpc_o` never rises without `acq_o`. A load never has `rel_o`. A store never has `acq_o` or `rcpc_o`. `excl_o` never appears with a register or immediate offset.
- R11: Any word that matches none of the families gives `dec_valid_o`=0, and every other output is 0.
- R12: For every valid word, `rt_o` = bits [4:0] and `rn_o` = bits [9:5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| dec_valid_o | output | 1 | Word belongs to a recognised family |
| is_load_o | output | 1 | 1 = load, 0 = store |
| size_o | output | 2 | log2 of the access byte count |
| rt_o | output | 5 | Data register index |
| rn_o | output | 5 | Base register index |
| off_is_reg_o | output | 1 | Offset comes from register `rm_o` |
| rm_o | output | 5 | Offset register index |
| off_imm_o | output | OFF_W | Immediate offset, zero-extended |
| acq_o | output | 1 | Acquire ordering (loads) |
| rcpc_o | output | 1 | Weaker processor-consistent acquire |
| excl_o | output | 1 | Exclusive access |
| rel_o | output | 1 | Release ordering (stores) |
| status_vld_o | output | 1 | `status_idx_o` carries a status register |
| status_idx_o | output | 5 | Status register of an exclusive store |

## Verification
The hardest words to produce are the near misses. These are words that differ from a valid family in one fixed bit. One case is the weakly ordered load against a register-offset word with opc 10, which are told apart only by bits [11:10]. Another is an exclusive store whose status field happens to be all ones, which looks almost like an exclusive load. The stimulus sweeps every value of the eleven high bits [31:21]. Each value is paired with low-field patterns chosen to land on each fixed-bit pattern, on the good and bad option and shift values, and on a status field of all ones and of another value. This reaches every family and all of its one-bit neighbours.

// File: rtl/ldst_dec_pkg.sv
package ldst_dec_pkg;

    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int SIZE_W  = 2;
    localparam int IMM12_W = 12;

    // field positions that the families share
    localparam int RT_LSB   = 0;
    localparam int RN_LSB   = 5;
    localparam int MID_LSB  = 16;
    localparam int IMM_LSB  = 10;
    localparam int SIZE_LSB = 30;

    typedef enum logic [2:0] {
        FORM_NONE = 3'd0,
        FORM_REG  = 3'd1,
        FORM_IMM  = 3'd2,
        FORM_ORD  = 3'd3,
        FORM_RCPC = 3'd4,
        FORM_LDX  = 3'd5,
        FORM_STX  = 3'd6
    } form_e;

    typedef struct packed {
        logic              valid;
        logic              is_load;
        logic [SIZE_W-1:0] size;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  rn;
        logic              off_reg;
        logic [REG_W-1:0]  rm;
        logic              acq;
        logic              rcpc;
        logic              excl;
        logic              rel;
        logic              stat_vld;
        logic [REG_W-1:0]  stat_idx;
    } uop_t;

endpackage

// File: rtl/ldst_form_match.sv
module ldst_form_match
    import ldst_dec_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output form_e             form_o
);

    logic [5:0]       grp;
    logic [1:0]       opc;
    logic             b21;
    logic [REG_W-1:0] mid;
    logic [2:0]       option;
    logic             shift_s;
    logic [1:0]       b11_10;
    logic [3:0]       b15_12;
    logic [4:0]       b14_10;
    logic             mid_ones;
    logic             tail_ones;

    assign grp       = insn_i[29:24];
    assign opc       = insn_i[23:22];
    assign b21       = insn_i[21];
    assign mid       = insn_i[MID_LSB +: REG_W];
    assign option    = insn_i[15:13];
    assign shift_s   = insn_i[12];
    assign b11_10    = insn_i[11:10];
    assign b15_12    = insn_i[15:12];
    assign b14_10    = insn_i[14:10];
    assign mid_ones  = (mid == '1);
    assign tail_ones = (b14_10 == '1);

    logic reg_ok;
    logic rcpc_ok;
    logic imm_ok;
    logic ord_ok;
    logic ldx_ok;
    logic stx_ok;

    always_comb begin
        reg_ok  = b21 && (b11_10 == 2'b10) && (option == 3'b011) &&
                  !shift_s && !opc[1];
        rcpc_ok = b21 && (opc == 2'b10) && mid_ones &&
                  (b15_12 == 4'b1100) && (b11_10 == 2'b00);
        imm_ok  = !opc[1];
        ord_ok  = opc[1] && !b21 && mid_ones && insn_i[15] && tail_ones;
        ldx_ok  = (opc == 2'b01) && !b21 && mid_ones && tail_ones;
        stx_ok  = (opc == 2'b00) && !b21 && tail_ones;
    end

    always_comb begin
        form_o = FORM_NONE;
        unique case (grp)
            6'b111000: begin
                if (reg_ok)       form_o = FORM_REG;
                else if (rcpc_ok) form_o = FORM_RCPC;
            end
            6'b111001: begin
                if (imm_ok)       form_o = FORM_IMM;
            end
            6'b001000: begin
                if (ord_ok)       form_o = FORM_ORD;
                else if (ldx_ok)  form_o = FORM_LDX;
                else if (stx_ok)  form_o = FORM_STX;
            end
            default: form_o = FORM_NONE;
        endcase
    end

endmodule

// File: rtl/ldst_uop_build.sv
module ldst_uop_build
    import ldst_dec_pkg::*;
#(
    parameter int OFF_W = 64
) (
    input  logic [INSN_W-1:0] insn_i,
    input  form_e             form_i,
    output uop_t              uop_o,
    output logic [OFF_W-1:0]  off_o
);

    logic [OFF_W-1:0]   imm_ext;
    logic [IMM12_W-1:0] imm12;

    assign imm12 = insn_i[IMM_LSB +: IMM12_W];

    generate
        if (OFF_W > IMM12_W) begin : g_widen
            assign imm_ext = {{(OFF_W-IMM12_W){1'b0}}, imm12};
        end else begin : g_narrow
            assign imm_ext = imm12[OFF_W-1:0];
        end
    endgenerate

    logic dir_bit;
    logic ord_bit;
    assign dir_bit = insn_i[22];
    assign ord_bit = insn_i[15];

    always_comb begin
        uop_o = '0;
        off_o = '0;
        if (form_i != FORM_NONE) begin
            uop_o.valid = 1'b1;
            uop_o.size  = insn_i[SIZE_LSB +: SIZE_W];
            uop_o.rt    = insn_i[RT_LSB +: REG_W];
            uop_o.rn    = insn_i[RN_LSB +: REG_W];
        end
        unique case (form_i)
            FORM_REG: begin
                uop_o.is_load = dir_bit;
                uop_o.off_reg = 1'b1;
                uop_o.rm      = insn_i[MID_LSB +: REG_W];
            end
            FORM_IMM: begin
                uop_o.is_load = dir_bit;
                off_o         = imm_ext;
            end
            FORM_ORD: begin
                uop_o.is_load = dir_bit;
                uop_o.acq     = dir_bit;
                uop_o.rel     = !dir_bit;
            end
            FORM_RCPC: begin
                uop_o.is_load = 1'b1;
                uop_o.acq     = 1'b1;
                uop_o.rcpc    = 1'b1;
            end
            FORM_LDX: begin
                uop_o.is_load = 1'b1;
                uop_o.excl    = 1'b1;
                uop_o.acq     = ord_bit;
            end
            FORM_STX: begin
                uop_o.excl     = 1'b1;
                uop_o.rel      = ord_bit;
                uop_o.stat_vld = 1'b1;
                uop_o.stat_idx = insn_i[MID_LSB +: REG_W];
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_dec_pkg::*;
#(
    parameter int OFF_W = 64
) (
    input  logic [31:0]      insn_i,
    output logic             dec_valid_o,
    output logic             is_load_o,
    output logic [1:0]       size_o,
    output logic [4:0]       rt_o,
    output logic [4:0]       rn_o,
    output logic             off_is_reg_o,
    output logic [4:0]       rm_o,
    output logic [OFF_W-1:0] off_imm_o,
    output logic             acq_o,
    output logic             rcpc_o,
    output logic             excl_o,
    output logic             rel_o,
    output logic             status_vld_o,
    output logic [4:0]       status_idx_o
);

    form_e            form;
    uop_t             uop;
    logic [OFF_W-1:0] off;

    ldst_form_match u_match (
        .insn_i (insn_i),
        .form_o (form)
    );

    ldst_uop_build #(
        .OFF_W (OFF_W)
    ) u_build (
        .insn_i (insn_i),
        .form_i (form),
        .uop_o  (uop),
        .off_o  (off)
    );

    assign dec_valid_o  = uop.valid;
    assign is_load_o    = uop.is_load;
    assign size_o       = uop.size;
    assign rt_o         = uop.rt;
    assign rn_o         = uop.rn;
    assign off_is_reg_o = uop.off_reg;
    assign rm_o         = uop.rm;
    assign off_imm_o    = off;
    assign acq_o        = uop.acq;
    assign rcpc_o       = uop.rcpc;
    assign excl_o       = uop.excl;
    assign rel_o        = uop.rel;
    assign status_vld_o = uop.stat_vld;
    assign status_idx_o = uop.stat_idx;

endmodule

// File: rtl/ldst_decode_chk.sv
module ldst_decode_chk #(
    parameter int OFF_W = 64
) (
    input logic [31:0]      insn_i,
    input logic             dec_valid_o,
    input logic             is_load_o,
    input logic [1:0]       size_o,
    input logic [4:0]       rt_o,
    input logic [4:0]       rn_o,
    input logic             off_is_reg_o,
    input logic [4:0]       rm_o,
    input logic [OFF_W-1:0] off_imm_o,
    input logic             acq_o,
    input logic             rcpc_o,
    input logic             excl_o,
    input logic             rel_o,
    input logic             status_vld_o,
    input logic [4:0]       status_idx_o
);

    logic any_out;
    assign any_out = is_load_o | (|size_o) | (|rt_o) | (|rn_o) | off_is_reg_o |
                     (|rm_o) | (|off_imm_o) | acq_o | rcpc_o | excl_o | rel_o |
                     status_vld_o | (|status_idx_o);

    always_comb begin
        if (!$isunknown(insn_i)) begin
            p_rcpc_needs_acq_r10: assert (!(rcpc_o && !acq_o));
            p_load_no_rel_r10:    assert (!(dec_valid_o && is_load_o && rel_o));
            p_store_no_acq_r10:   assert (!(dec_valid_o && !is_load_o && (acq_o || rcpc_o)));
            p_status_only_stx_r9: assert (!status_vld_o || (dec_valid_o && !is_load_o && excl_o));
            p_stx_has_status_r8:  assert (!(dec_valid_o && !is_load_o && excl_o && !status_vld_o));
            p_reg_plain_r2:       assert (!(off_is_reg_o && (excl_o || acq_o || rel_o || (|off_imm_o))));
            p_imm_narrow_r4:      assert ((off_imm_o >> 12) == '0);
            p_invalid_quiet_r11:  assert (dec_valid_o || !any_out);
        end
    end

endmodule

bind ldst_decode ldst_decode_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/ldst_decode_bench.sv
module ldst_decode_bench;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 64;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0]      insn;
    logic             dec_valid, is_load, off_is_reg, acq, rcpc, excl, rel, status_vld;
    logic [1:0]       size;
    logic [4:0]       rt, rn, rm, status_idx;
    logic [OFF_W-1:0] off_imm;

    ldst_decode #(.OFF_W(OFF_W)) u_ldst_decode (
        .insn_i       (insn),
        .dec_valid_o  (dec_valid),
        .is_load_o    (is_load),
        .size_o       (size),
        .rt_o         (rt),
        .rn_o         (rn),
        .off_is_reg_o (off_is_reg),
        .rm_o         (rm),
        .off_imm_o    (off_imm),
        .acq_o        (acq),
        .rcpc_o       (rcpc),
        .excl_o       (excl),
        .rel_o        (rel),
        .status_vld_o (status_vld),
        .status_idx_o (status_idx)
    );

    typedef struct packed {
        logic             v;
        logic             ld;
        logic [1:0]       sz;
        logic [4:0]       rt;
        logic [4:0]       rn;
        logic             isreg;
        logic [4:0]       rm;
        logic [OFF_W-1:0] off;
        logic             acq;
        logic             rc;
        logic             ex;
        logic             rel;
        logic             sv;
        logic [4:0]       si;
    } exp_t;

    int n_chk = 0;
    int n_err = 0;

    logic [5:0] mids [8] = '{6'b111111, 6'b011111, 6'b110000, 6'b011010,
                             6'b011110, 6'b111010, 6'b010000, 6'b101011};
    logic [4:0] rsv  [2] = '{5'b11111, 5'b00110};

    function automatic exp_t ref_dec(input logic [31:0] w, output string tag);
        exp_t       e;
        logic [1:0] opc;
        e   = '0;
        tag = "R11";
        opc = w[23:22];
        if (w ==? 32'b??_111000_??_1_?????_???_?_10_?????_?????) begin
            tag = opc[1] ? "R3" : "R2";
            if (!opc[1] && w[15:13] == 3'b011 && !w[12]) begin
                e.v = 1'b1; e.ld = opc[0]; e.isreg = 1'b1; e.rm = w[20:16];
            end
        end else if (w ==? 32'b??_111001_??_????????????_?????_?????) begin
            tag = opc[1] ? "R3" : "R4";
            if (!opc[1]) begin
                e.v = 1'b1; e.ld = opc[0]; e.off = OFF_W'(w[21:10]);
            end
        end else if (w ==? 32'b??_111000_10_1_11111_1100_00_?????_?????) begin
            tag = "R6";
            e.v = 1'b1; e.ld = 1'b1; e.acq = 1'b1; e.rc = 1'b1;
        end else if (w ==? 32'b??_001000_1_?_0_11111_1_11111_?????_?????) begin
            tag = "R5";
            e.v = 1'b1; e.ld = w[22]; e.acq = w[22]; e.rel = !w[22];
        end else if (w ==? 32'b??_001000_0_1_0_11111_?_11111_?????_?????) begin
            tag = "R7";
            e.v = 1'b1; e.ld = 1'b1; e.ex = 1'b1; e.acq = w[15];
        end else if (w ==? 32'b??_001000_0_0_0_?????_?_11111_?????_?????) begin
            tag = "R8";
            e.v = 1'b1; e.ex = 1'b1; e.rel = w[15]; e.sv = 1'b1; e.si = w[20:16];
        end
        if (e.v) begin
            e.sz = w[31:30]; e.rt = w[4:0]; e.rn = w[9:5];
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s insn=%h actual=%h expected=%h", req, insn, act, expv);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        exp_t  e;
        exp_t  g;
        string tag;
        @(posedge clk);
        insn = w;
        @(negedge clk);
        e = ref_dec(w, tag);
        g.v = dec_valid; g.ld = is_load; g.sz = size; g.rt = rt; g.rn = rn;
        g.isreg = off_is_reg; g.rm = rm; g.off = off_imm; g.acq = acq; g.rc = rcpc;
        g.ex = excl; g.rel = rel; g.sv = status_vld; g.si = status_idx;
        // R1 R12: size and register indices on any valid word
        if (e.v)
            chk({g.sz, g.rt, g.rn} === {e.sz, e.rt, e.rn}, "R1 R12",
                128'({g.sz, g.rt, g.rn}), 128'({e.sz, e.rt, e.rn}));
        // family-specific fields (R2..R8, R9 zero status, R11 quiet)
        chk(g === e, tag, 128'(g), 128'(e));
        // R10: flag consistency seen at the ports
        chk(!(g.rc && !g.acq) && !(g.v && g.ld && g.rel) &&
            !(g.v && !g.ld && (g.acq || g.rc)) && !(g.ex && g.isreg) &&
            !(g.ex && g.off != '0), "R10", 128'(g), 128'(e));
        // R9: status only on exclusive stores
        if (!(e.v && e.ex && !e.ld))
            chk(!g.sv && g.si == '0, "R9", 128'({g.sv, g.si}), 128'(0));
    endtask

    initial begin
        insn = '0;
        // idle word: nothing recognised (R11)
        apply(32'h0000_0000);
        // directed: immediate with all-ones offset (R4)
        apply({2'b11, 6'b111001, 2'b01, 12'hFFF, 5'd7, 5'd9});
        // directed: weakly ordered acquire (R6) vs opc 10 register word (R3)
        apply({2'b10, 6'b111000, 2'b10, 1'b1, 5'b11111, 4'b1100, 2'b00, 5'd3, 5'd4});
        apply({2'b10, 6'b111000, 2'b10, 1'b1, 5'b11111, 3'b011, 1'b0, 2'b10, 5'd3, 5'd4});
        // directed: exclusive store with status 31 (R8) and release set
        apply({2'b01, 6'b001000, 3'b000, 5'b11111, 1'b1, 5'b11111, 5'd1, 5'd2});
        // sweep of high bits against chosen low patterns
        for (int hi = 0; hi < 2048; hi++) begin
            for (int ri = 0; ri < 2; ri++) begin
                for (int mi = 0; mi < 8; mi++) begin
                    logic [4:0] rn_v;
                    logic [4:0] rt_v;
                    rn_v = 5'((hi ^ mi) & 31);
                    rt_v = 5'((hi * 3 + ri + mi) & 31);
                    apply({hi[10:0], rsv[ri], mids[mi], rn_v, rt_v});
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule